// File: doc/BRIEF.md
# Dual-Channel Power-Good Reset Generator

This block produces one active-low reset for each of two voltage regulators. Each channel receives two digitised comparator flags. One flag says the regulator output sits above the upper (94 %) threshold. The other says it sits below the lower (90 %) threshold. A free-running one-cycle microsecond tick is shared by both channels.

A channel becomes power-good only when its upper flag has been present on an unbroken run of ticks as long as its entry delay. It drops out only after an unbroken run of lower-flag ticks as long as its exit delay. The band between the thresholds gives hysteresis, and the unequal delays make the reset slow to release but quick to reassert.

Channel 1 has a fixed entry delay of about 2 ms and a fixed exit delay. Channel 2 takes its entry delay from a programmable value, and its exit delay is derived from that same value. Every exit delay has a floor. Each channel's output is a pull-low enable that stands for an open-drain reset pin: 1 means the pin is pulled low, 0 means it is released.

Top module: `pgr_dual`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, both channels are not power-good and `pull_low` is 2'b11.
- R2: A not-power-good, enabled channel becomes power-good in the cycle after the tick on which its upper flag has been high for the entry delay count D of consecutive ticks. The flag must also have stayed high in every cycle between those ticks.
- R3: A power-good channel becomes not-power-good in the cycle after the tick on which its lower flag has been high for the exit delay count E of consecutive ticks. The flag must also have stayed high in every cycle between those ticks.
- R4: Any cycle in which the pending condition is false (upper flag while waiting to enter, lower flag while waiting to leave) restarts that count from zero.
- R5: Channel 1 (index 0) uses D = 2000 ticks and E = 25 ticks.
- R6: Channel 2 (index 1) uses D = `ch2_entry_us`, with a value of 0 treated as 1. It uses E = `ch2_entry_us` >> 13, so a setting of 200000 gives 24.
- R7: No exit delay is ever shorter than 10 ticks. A smaller derived value is raised to 10.
- R8: A channel whose `reg_en` bit is low is forced not-power-good the next cycle. Its count is cleared, so a full entry delay is needed after it is re-enabled.
- R9: The encoding of `pull_low[i]` is 1 when channel i is not power-good and 0 when it is power-good.
- R10: The two channels qualify independently. Flags and enables on one channel never change the other channel's output.
- R11: Cycles without `us_tick` never advance a count, so with the channel enabled the power-good state holds across them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| reg_en | input | 2 | Regulator enable per channel (bit 0 = channel 1) |
| above_hi | input | 2 | Output above upper threshold, per channel |
| below_lo | input | 2 | Output below lower threshold, per channel |
| ch2_entry_us | input | DLY_W | Channel 2 entry delay in ticks |
| pull_low | output | 2 | 1 = reset pin pulled low, 0 = released |

## Verification
If a count is lost or sticks, the release edge moves away from the exact tick on which it is due. The bench therefore samples each release and reassert one tick before it is due and on the tick it is due. A derived exit delay that comes out wrong for channel 2, or a missing floor, shows within a dozen ticks of the lower flag rising. State that leaks between channels, or a count that survives a disable, shows as an output that changes on the wrong channel or too early in the cycle after the stimulus. Long random flag patterns, with gaps in the tick, are compared every cycle against a model built from the requirements.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

    typedef struct packed {
        logic en;
        logic above;
        logic below;
    } chan_sense_t;

    typedef enum logic {
        PG_LOW  = 1'b0,
        PG_GOOD = 1'b1
    } pg_state_e;

    function automatic int unsigned exit_from_entry(
        input int unsigned entry,
        input int unsigned shift,
        input int unsigned floor_ticks
    );
        int unsigned e;
        e = entry >> shift;
        return (e < floor_ticks) ? floor_ticks : e;
    endfunction

endpackage

// File: rtl/pgr_delay_sel.sv
module pgr_delay_sel #(
    parameter int DLY_W      = 20,
    parameter bit FIXED      = 1'b1,
    parameter int FIX_ENTRY  = 2000,
    parameter int FIX_EXIT   = 25,
    parameter int EXIT_SHIFT = 13,
    parameter int MIN_EXIT   = 10
) (
    input  logic [DLY_W-1:0] prog_entry,
    output logic [DLY_W-1:0] entry_lim,
    output logic [DLY_W-1:0] exit_lim
);
    import pgr_pkg::*;

    localparam int unsigned FIX_EXIT_CL =
        (FIX_EXIT < MIN_EXIT) ? MIN_EXIT : FIX_EXIT;

    logic [DLY_W-1:0] prog_nz;

    always_comb begin
        prog_nz = (prog_entry == '0) ? DLY_W'(1) : prog_entry;
        if (FIXED) begin
            entry_lim = DLY_W'(FIX_ENTRY);
            exit_lim  = DLY_W'(FIX_EXIT_CL);
        end else begin
            entry_lim = prog_nz;
            exit_lim  = DLY_W'(exit_from_entry(32'(prog_entry),
                                               EXIT_SHIFT, MIN_EXIT));
        end
    end
endmodule

// File: rtl/pgr_qual.sv
module pgr_qual #(
    parameter int DLY_W    = 20,
    parameter int MIN_EXIT = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  pgr_pkg::chan_sense_t sense,
    input  logic [DLY_W-1:0]    entry_lim,
    input  logic [DLY_W-1:0]    exit_lim,
    output logic                pull_low
);
    import pgr_pkg::*;

    pg_state_e        st;
    logic [DLY_W-1:0] cnt;
    logic [DLY_W:0]   cnt_nx;
    logic [DLY_W-1:0] lim;
    logic             cond;
    logic             pg;

    always_comb begin
        pg     = (st == PG_GOOD);
        cond   = pg ? sense.below : sense.above;
        lim    = pg ? exit_lim : entry_lim;
        cnt_nx = {1'b0, cnt} + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= PG_LOW;
            cnt <= '0;
        end else if (!sense.en) begin
            st  <= PG_LOW;
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (tick) begin
            if (cnt_nx >= {1'b0, lim}) begin
                st  <= pg ? PG_LOW : PG_GOOD;
                cnt <= '0;
            end else begin
                cnt <= cnt_nx[DLY_W-1:0];
            end
        end
    end

    assign pull_low = ~pg;

    assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(pg) |-> $past(sense.en && sense.above && tick));

    assert_exit_qualified_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pg) |-> $past(!sense.en || (sense.below && tick)));

    assert_disable_forces_low_R8: assert property (@(posedge clk) disable iff (rst)
        !sense.en |=> !pg);

    assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (rst)
        (sense.en && !tick) |=> $stable(pg));

    assert_exit_floor_R7: assert property (@(posedge clk) disable iff (rst)
        exit_lim >= DLY_W'(MIN_EXIT));
endmodule

// File: rtl/pgr_dual.sv
module pgr_dual #(
    parameter int DLY_W        = 20,
    parameter int CH1_ENTRY_US = 2000,
    parameter int CH1_EXIT_US  = 25,
    parameter int EXIT_SHIFT   = 13,
    parameter int MIN_EXIT_US  = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             us_tick,
    input  logic [1:0]       reg_en,
    input  logic [1:0]       above_hi,
    input  logic [1:0]       below_lo,
    input  logic [DLY_W-1:0] ch2_entry_us,
    output logic [1:0]       pull_low
);
    import pgr_pkg::*;

    localparam int NCH = 2;

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
            logic [DLY_W-1:0] entry_lim;
            logic [DLY_W-1:0] exit_lim;
            chan_sense_t      sense;

            assign sense = '{en: reg_en[ch], above: above_hi[ch], below: below_lo[ch]};

            pgr_delay_sel #(
                .DLY_W     (DLY_W),
                .FIXED     (ch == 0),
                .FIX_ENTRY (CH1_ENTRY_US),
                .FIX_EXIT  (CH1_EXIT_US),
                .EXIT_SHIFT(EXIT_SHIFT),
                .MIN_EXIT  (MIN_EXIT_US)
            ) u_dly (
                .prog_entry(ch2_entry_us),
                .entry_lim (entry_lim),
                .exit_lim  (exit_lim)
            );

            pgr_qual #(
                .DLY_W   (DLY_W),
                .MIN_EXIT(MIN_EXIT_US)
            ) u_qual (
                .clk      (clk),
                .rst      (rst),
                .tick     (us_tick),
                .sense    (sense),
                .entry_lim(entry_lim),
                .exit_lim (exit_lim),
                .pull_low (pull_low[ch])
            );
        end
    endgenerate
endmodule

// File: tb/pgr_dual_test.sv
module pgr_dual_test;
    localparam int DLY_W = 20;

    logic             clk = 1'b0;
    logic             rst;
    logic             us_tick;
    logic [1:0]       reg_en;
    logic [1:0]       above_hi;
    logic [1:0]       below_lo;
    logic [DLY_W-1:0] ch2_entry_us;
    logic [1:0]       pull_low;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    int mcnt [2];
    bit mgood[2];

    always #5 clk = ~clk;

    pgr_dual uut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .reg_en(reg_en),
        .above_hi(above_hi), .below_lo(below_lo),
        .ch2_entry_us(ch2_entry_us), .pull_low(pull_low)
    );

    function automatic int entry_d(int ch);
        if (ch == 0) return 2000;
        return (ch2_entry_us == 0) ? 1 : int'(ch2_entry_us);
    endfunction

    function automatic int exit_d(int ch);
        int e;
        if (ch == 0) return 25;
        e = int'(ch2_entry_us) >> 13;
        return (e < 10) ? 10 : e;
    endfunction

    task automatic model_step();
        for (int ch = 0; ch < 2; ch++) begin
            bit cond;
            int lim;
            if (rst || !reg_en[ch]) begin
                mgood[ch] = 0; mcnt[ch] = 0;
            end else begin
                cond = mgood[ch] ? below_lo[ch] : above_hi[ch];
                lim  = mgood[ch] ? exit_d(ch) : entry_d(ch);
                if (!cond) mcnt[ch] = 0;
                else if (us_tick) begin
                    if (mcnt[ch] + 1 >= lim) begin
                        mgood[ch] = !mgood[ch]; mcnt[ch] = 0;
                    end else mcnt[ch]++;
                end
            end
        end
    endtask

    task automatic chk(int ch, bit exp, string tag);
        n_checks++;
        if (pull_low[ch] !== exp) begin
            n_fails++;
            $display("FAIL %s ch%0d pull_low actual=%b expected=%b t=%0t",
                     tag, ch, pull_low[ch], exp, $time);
        end
    endtask

    task automatic cyc(int n, bit t, string tag);
        for (int i = 0; i < n; i++) begin
            us_tick = t;
            @(posedge clk); #1;
            model_step();
            for (int ch = 0; ch < 2; ch++) chk(ch, !mgood[ch], tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240601));
        rst = 1; us_tick = 0; reg_en = 0; above_hi = 0; below_lo = 0;
        ch2_entry_us = 20'd300;
        mgood[0] = 0; mgood[1] = 0; mcnt[0] = 0; mcnt[1] = 0;
        #1;
        cyc(3, 1, "R1");
        chk(0, 1, "R1"); chk(1, 1, "R1");
        rst = 0;
        cyc(1, 1, "R1");
        chk(0, 1, "R1"); chk(1, 1, "R1");
        reg_en = 2'b11;
        cyc(5, 1, "R9");

        // R2 R5: channel 1 entry at exactly 2000 ticks
        above_hi[0] = 1;
        cyc(1999, 1, "R2");
        chk(0, 1, "R5 entry-1");
        cyc(1, 1, "R2");
        chk(0, 0, "R5 entry");
        chk(1, 1, "R10");

        // R3 R5: exit at exactly 25 ticks
        above_hi[0] = 0; below_lo[0] = 1;
        cyc(24, 1, "R3");
        chk(0, 0, "R5 exit-1");
        cyc(1, 1, "R3");
        chk(0, 1, "R5 exit");

        // R4: breaks restart the counts
        below_lo[0] = 0; above_hi[0] = 1;
        cyc(1500, 1, "R4");
        above_hi[0] = 0;
        cyc(1, 1, "R4");
        above_hi[0] = 1;
        cyc(1999, 1, "R4");
        chk(0, 1, "R4 entry restart");
        cyc(1, 1, "R4");
        chk(0, 0, "R4 entry");
        above_hi[0] = 0; below_lo[0] = 1;
        cyc(20, 1, "R4");
        below_lo[0] = 0;
        cyc(1, 1, "R4");
        below_lo[0] = 1;
        cyc(24, 1, "R4");
        chk(0, 0, "R4 exit restart");
        cyc(1, 1, "R4");
        chk(0, 1, "R4 exit");

        // R11: no tick, no progress
        below_lo[0] = 0; above_hi[0] = 1;
        cyc(3000, 0, "R11");
        chk(0, 1, "R11 idle");
        cyc(2000, 1, "R11");
        chk(0, 0, "R11 ticked");
        cyc(500, 0, "R11");
        chk(0, 0, "R11 hold");

        // R8: disable forces low and clears count
        reg_en[0] = 0;
        cyc(1, 1, "R8");
        chk(0, 1, "R8 disable");
        reg_en[0] = 1;
        cyc(1999, 1, "R8");
        chk(0, 1, "R8 full delay");
        cyc(1, 1, "R8");
        chk(0, 0, "R8 reentry");

        // R6 R7: channel 2 with small setting, floor applies
        above_hi[1] = 1;
        cyc(299, 1, "R6");
        chk(1, 1, "R6 entry-1");
        chk(0, 0, "R10");
        cyc(1, 1, "R6");
        chk(1, 0, "R6 entry");
        above_hi[1] = 0; below_lo[1] = 1;
        cyc(9, 1, "R7");
        chk(1, 0, "R7 exit-1");
        cyc(1, 1, "R7");
        chk(1, 1, "R7 floor");

        // R6: zero setting means one tick
        ch2_entry_us = 0; below_lo[1] = 0; above_hi[1] = 1;
        cyc(1, 1, "R6");
        chk(1, 0, "R6 zero");
        above_hi[1] = 0; below_lo[1] = 1;
        cyc(10, 1, "R7");
        chk(1, 1, "R7 zero");

        // R6: large setting, exit scales to 12
        reg_en[0] = 0;
        ch2_entry_us = 20'd98304; below_lo[1] = 0; above_hi[1] = 1;
        cyc(98303, 1, "R6");
        chk(1, 1, "R6 long-1");
        cyc(1, 1, "R6");
        chk(1, 0, "R6 long");
        above_hi[1] = 0; below_lo[1] = 1;
        cyc(11, 1, "R6");
        chk(1, 0, "R6 scaled exit-1");
        cyc(1, 1, "R6");
        chk(1, 1, "R6 scaled exit");

        // random segments, R10 and all rules together
        for (int s = 0; s < 28; s++) begin
            int len;
            len = 50 + int'($urandom % 2200);
            ch2_entry_us = DLY_W'(1 + $urandom % 400);
            for (int ch = 0; ch < 2; ch++) begin
                int lvl;
                lvl = int'($urandom % 3);
                above_hi[ch] = (lvl == 2);
                below_lo[ch] = (lvl == 0);
                reg_en[ch]   = ($urandom % 8) != 0;
            end
            for (int i = 0; i < len; i++) begin
                if (($urandom % 64) == 0) begin
                    int ch;
                    ch = int'($urandom % 2);
                    above_hi[ch] = ~above_hi[ch];
                    below_lo[ch] = 0;
                end
                cyc(1, ($urandom % 8) != 0, "R10 random");
            end
        end

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule